// File: doc/BRIEF.md
# Four-Channel DMA Request Controller

This block keeps the control state of a small set of DMA channels and turns device transfer requests into memory transfer commands. Software programs each channel through a 32-bit register window: a mode word (enable, direction and three status flags), a remaining byte count, and a start address. A device raises its request line together with a direction and a wanted length.

Each cycle the block serves at most one request. The lowest-numbered requesting channel wins. The block checks that channel and then does one of two things:

- **Accepted:** it clips the length to the remaining count, issues one command carrying address, length and direction on the following cycle, decrements the count and flags terminal count.
- **Rejected:** the channel is disabled or the direction is wrong. It flags a memory error in the channel's mode word and latches the channel into a shared error-source word. No command is issued.

The data movement and any address translation are done downstream of the command port.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset every channel's mode, count and address registers read 0, the error-source word reads 0 and no command is valid.
- R2: Channel n's registers sit at byte offsets 0x100 + 0x20·n + 8·k, with k=1 the mode word, k=2 the byte count and k=3 the start address. They are written and read back as full 32-bit words. Slot k=0, offsets not a multiple of 8 and all other unmapped offsets read 0, and writes to them change nothing.
- R3: `req_gnt` is combinational and one-hot or zero. It marks the lowest-numbered channel whose `req` is high, so one request is served per cycle.
- R4: A served request is rejected when mode bit 0 (enable) is 0, or when the direction disagrees with mode bit 1. Bit 1 = 0 means device-to-memory and requires `req_dev_wr`=1. Bit 1 = 1 means memory-to-device and requires `req_dev_wr`=0.
- R5: On rejection the mode word gets bit 9 set and bits 8 and 10 cleared. Bit n of the error-source word (offset 0x200) is set and stays set until reset. No command is issued.
- R6: On acceptance, `xfer_valid` is high for one cycle, one clock after the grant. The command carries:
  - the channel number;
  - the address register;
  - length = min(requested length, count register);
  - `xfer_to_dev` equal to mode bit 1.
- R7: On acceptance the count register drops by the issued length, mode bit 8 is set and bits 9 and 10 are cleared. All other mode bits are kept.
- R8: A request on an enabled, correctly directed channel whose count is 0 is still accepted. It issues a zero-length command and leaves the count at 0.
- R9: The error-source word is read-only: writes to offset 0x200 leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| req | input | NCH | Per-channel transfer request, held until granted |
| req_dev_wr | input | NCH | Per-channel direction: 1 = device writes memory |
| req_len | input | NCH*32 | Per-channel wanted length, channel n in bits [32n+31:32n] |
| req_gnt | output | NCH | Channel served this cycle |
| xfer_valid | output | 1 | Memory transfer command valid |
| xfer_chan | output | CHW | Channel of the command |
| xfer_addr | output | 32 | Start address of the command |
| xfer_len | output | 32 | Length of the command |
| xfer_to_dev | output | 1 | Command direction: 1 = memory to device |

## Verification
Results are due at different times:

- **Grant:** due in the same cycle as the request, so the bench samples it one time unit after driving inputs on the falling edge.
- **Command and register updates:** the transfer command, the count and mode updates and the error-source bit all take effect at the next rising edge. The bench compares them at the falling edge that follows.
- **Register reads:** purely combinational, so they are checked a moment after the address is set, with no clock in between.

The reference model applies each served request to its own copy of the registers at the same step the RTL does. Every comparison therefore lines up with the cycle in which the value is due.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;
  localparam int WORD_W    = 32;
  typedef logic [WORD_W-1:0] word_t;

  // mode word bit positions
  localparam int MB_EN     = 0;
  localparam int MB_TODEV  = 1;
  localparam int MB_TC     = 8;
  localparam int MB_MERR   = 9;
  localparam int MB_AERR   = 10;

  // register window layout
  localparam int CH_BASE   = 'h100;
  localparam int CH_SHIFT  = 5;
  localparam int REG_SHIFT = 3;
  localparam int ERR_OFF   = 'h200;

  localparam logic [1:0] IDX_MODE = 2'd1;
  localparam logic [1:0] IDX_CNT  = 2'd2;
  localparam logic [1:0] IDX_ADDR = 2'd3;

  function automatic word_t clip_len(word_t want, word_t left);
    return (want < left) ? want : left;
  endfunction

  function automatic logic req_ok(word_t mode, logic dev_wr);
    return mode[MB_EN] && (dev_wr == !mode[MB_TODEV]);
  endfunction

  function automatic word_t mode_after(word_t mode, logic ok);
    word_t m;
    m = mode;
    m[MB_TC]   = ok;
    m[MB_MERR] = !ok;
    m[MB_AERR] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/dma_cc_arb.sv
module dma_cc_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt,
  output logic         any
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_pick
    assign gnt[gi]    = req[gi] & ~seen[gi];
    assign seen[gi+1] = seen[gi] | req[gi];
  end

  assign any = seen[N];
endmodule

// File: rtl/dma_cc_chan.sv
module dma_cc_chan
  import dma_cc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  word_t      wdata,
  input  logic       svc,
  input  logic       dev_wr,
  input  word_t      want_len,
  output word_t      mode_q,
  output word_t      cnt_q,
  output word_t      addr_q,
  output logic       ok,
  output word_t      use_len
);
  assign ok      = req_ok(mode_q, dev_wr);
  assign use_len = clip_len(want_len, cnt_q);

  // A software write in the same cycle as a service update wins (last assignment).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      if (svc) begin
        mode_q <= mode_after(mode_q, ok);
        if (ok) cnt_q <= cnt_q - use_len;
      end
      if (wr_en) begin
        case (wr_sel)
          IDX_MODE: mode_q <= wdata;
          IDX_CNT:  cnt_q  <= wdata;
          IDX_ADDR: addr_q <= wdata;
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_cc_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int AW  = 10,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    req_dev_wr,
  input  logic [NCH*32-1:0] req_len,
  output logic [NCH-1:0]    req_gnt,
  output logic              xfer_valid,
  output logic [CHW-1:0]    xfer_chan,
  output logic [31:0]       xfer_addr,
  output logic [31:0]       xfer_len,
  output logic              xfer_to_dev
);
  localparam logic [AW-1:0] CH_LO  = AW'(CH_BASE);
  localparam logic [AW-1:0] CH_HI  = AW'(CH_BASE + (NCH << CH_SHIFT));
  localparam logic [AW-1:0] ERR_AD = AW'(ERR_OFF);

  // register window decode
  logic [AW-1:0]  rel;
  logic           hit_ch;
  logic [CHW-1:0] acc_ch;
  logic [1:0]     acc_idx;

  assign rel     = reg_addr - CH_LO;
  assign hit_ch  = (reg_addr >= CH_LO) && (reg_addr < CH_HI) && (reg_addr[2:0] == 3'b000);
  assign acc_ch  = CHW'(rel >> CH_SHIFT);
  assign acc_idx = 2'(rel >> REG_SHIFT);

  // per-channel state
  word_t    mode_v [NCH];
  word_t    cnt_v  [NCH];
  word_t    addr_v [NCH];
  word_t    len_v  [NCH];
  logic [NCH-1:0] ok_v;
  logic     svc_any;

  dma_cc_arb #(.N(NCH)) u_arb (.req(req), .gnt(req_gnt), .any(svc_any));

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    logic wr_here;
    assign wr_here = reg_wr && hit_ch && (acc_ch == CHW'(gc));
    dma_cc_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_here),
      .wr_sel  (acc_idx),
      .wdata   (reg_wdata),
      .svc     (req_gnt[gc]),
      .dev_wr  (req_dev_wr[gc]),
      .want_len(req_len[gc*32 +: 32]),
      .mode_q  (mode_v[gc]),
      .cnt_q   (cnt_v[gc]),
      .addr_q  (addr_v[gc]),
      .ok      (ok_v[gc]),
      .use_len (len_v[gc])
    );
  end

  // served-channel selection, brought out as named events
  logic           sel_ok;
  word_t          sel_len;
  word_t          sel_addr;
  logic           sel_todev;
  logic [CHW-1:0] sel_ch;
  logic           svc_ok;
  logic           svc_rej;

  always_comb begin
    sel_ok    = 1'b0;
    sel_len   = '0;
    sel_addr  = '0;
    sel_todev = 1'b0;
    sel_ch    = '0;
    for (int i = 0; i < NCH; i++) begin
      if (req_gnt[i]) begin
        sel_ok    = ok_v[i];
        sel_len   = len_v[i];
        sel_addr  = addr_v[i];
        sel_todev = mode_v[i][MB_TODEV];
        sel_ch    = CHW'(i);
      end
    end
  end

  assign svc_ok  = svc_any && sel_ok;
  assign svc_rej = svc_any && !sel_ok;

  // command port and error-source word
  logic [NCH-1:0] err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid  <= 1'b0;
      xfer_chan   <= '0;
      xfer_addr   <= '0;
      xfer_len    <= '0;
      xfer_to_dev <= 1'b0;
      err_q       <= '0;
    end else begin
      xfer_valid <= svc_ok;
      if (svc_ok) begin
        xfer_chan   <= sel_ch;
        xfer_addr   <= sel_addr;
        xfer_len    <= sel_len;
        xfer_to_dev <= sel_todev;
      end
      if (svc_rej) err_q <= err_q | req_gnt;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (hit_ch) begin
      case (acc_idx)
        IDX_MODE: reg_rdata = mode_v[acc_ch];
        IDX_CNT:  reg_rdata = cnt_v[acc_ch];
        IDX_ADDR: reg_rdata = addr_v[acc_ch];
        default:  reg_rdata = '0;
      endcase
    end else if (reg_addr == ERR_AD) begin
      reg_rdata = 32'(err_q);
    end
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] req_gnt,
  input logic           svc_ok,
  input logic           svc_rej,
  input logic           xfer_valid,
  input logic [NCH-1:0] err_q
);
  assert_gnt_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_gnt));

  assert_gnt_subset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_gnt & ~req) == '0);

  assert_gnt_when_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (req_gnt != '0));

  assert_issue_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> xfer_valid);

  assert_reject_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_rej |=> !xfer_valid);

  assert_err_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_rej |=> ((err_q & $past(req_gnt)) == $past(req_gnt)));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q & $past(err_q)) == $past(err_q));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req       (req),
  .req_gnt   (req_gnt),
  .svc_ok    (svc_ok),
  .svc_rej   (svc_rej),
  .xfer_valid(xfer_valid),
  .err_q     (err_q)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [9:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  req;
  logic [3:0]  req_dev_wr;
  logic [31:0] blen [4];
  logic [127:0] req_len;
  logic [3:0]  req_gnt;
  logic        xfer_valid;
  logic [1:0]  xfer_chan;
  logic [31:0] xfer_addr;
  logic [31:0] xfer_len;
  logic        xfer_to_dev;

  int total = 0;
  int bad   = 0;

  // reference state
  logic [31:0] m_mode [4];
  logic [31:0] m_cnt  [4];
  logic [31:0] m_addr [4];
  logic [3:0]  m_err;

  always #4 clk = ~clk;

  assign req_len = {blen[3], blen[2], blen[1], blen[0]};

  dma_chan_ctrl i_dma_chan_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req),
    .req_dev_wr(req_dev_wr), .req_len(req_len), .req_gnt(req_gnt),
    .xfer_valid(xfer_valid), .xfer_chan(xfer_chan), .xfer_addr(xfer_addr),
    .xfer_len(xfer_len), .xfer_to_dev(xfer_to_dev)
  );

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!good) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int off(input int ch, input int k);
    return 256 + 32 * ch + 8 * k;
  endfunction

  // one clock: check grant, advance model, check command port
  task automatic step();
    int g = -1;
    bit exv = 1'b0;
    logic [31:0] e_len = 0, e_addr = 0;
    logic e_dir = 1'b0;
    for (int i = 0; i < 4; i++) if (req[i] && g < 0) g = i;
    #1;
    chk(req_gnt == ((g < 0) ? 4'b0 : 4'(1 << g)), "R3 grant", 32'(req_gnt), (g < 0) ? 0 : (1 << g));
    if (g >= 0) begin
      logic [31:0] m;
      bit accept;
      m = m_mode[g] & ~32'h700;
      accept = m_mode[g][0] && ((req_dev_wr[g] == 1'b1) == (m_mode[g][1] == 1'b0));
      if (accept) begin
        e_len  = (blen[g] < m_cnt[g]) ? blen[g] : m_cnt[g];
        e_addr = m_addr[g];
        e_dir  = m_mode[g][1];
        exv    = 1'b1;
        m_cnt[g] = m_cnt[g] - e_len;
        m = m | 32'h100;
      end else begin
        m = m | 32'h200;
        m_err[g] = 1'b1;
      end
      m_mode[g] = m;
    end
    if (reg_wr) begin
      for (int c = 0; c < 4; c++) begin
        if (int'(reg_addr) == off(c, 1)) m_mode[c] = reg_wdata;
        if (int'(reg_addr) == off(c, 2)) m_cnt[c]  = reg_wdata;
        if (int'(reg_addr) == off(c, 3)) m_addr[c] = reg_wdata;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(xfer_valid == exv, "R6 xfer_valid", 32'(xfer_valid), 32'(exv));
    if (exv) begin
      chk(int'(xfer_chan) == g, "R6 chan", 32'(xfer_chan), g);
      chk(xfer_addr == e_addr, "R6 addr", xfer_addr, e_addr);
      chk(xfer_len == e_len, "R6 len", xfer_len, e_len);
      chk(xfer_to_dev == e_dir, "R6 dir", 32'(xfer_to_dev), 32'(e_dir));
    end
    if (g >= 0) req[g] = 1'b0;
    reg_wr = 1'b0;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = 10'(a); reg_wdata = d;
    step();
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    reg_addr = 10'(a);
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic ask(input int ch, input bit dev_wr, input logic [31:0] len);
    req[ch] = 1'b1; req_dev_wr[ch] = dev_wr; blen[ch] = len;
  endtask

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    req = '0; req_dev_wr = '0;
    for (int i = 0; i < 4; i++) begin
      blen[i] = '0; m_mode[i] = '0; m_cnt[i] = '0; m_addr[i] = '0;
    end
    m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(xfer_valid == 1'b0, "R1 xfer_valid", 32'(xfer_valid), 0);
    for (int c = 0; c < 4; c++)
      for (int k = 1; k < 4; k++) rd(off(c, k), 0, "R1 channel reg");
    rd('h200, 0, "R1 error word");

    // R2: register window, R9: error word read-only
    wr(off(0, 1), 32'h1);
    wr(off(0, 2), 32'd100);
    wr(off(0, 3), 32'h0000_1000);
    rd(off(0, 1), 32'h1, "R2 mode readback");
    rd(off(0, 2), 32'd100, "R2 count readback");
    rd(off(0, 3), 32'h1000, "R2 addr readback");
    wr(off(0, 0), 32'hDEAD_BEEF);
    rd(off(0, 0), 0, "R2 slot 0 reads 0");
    wr(off(0, 1) + 4, 32'hFFFF_FFFF);
    rd(off(0, 1), 32'h1, "R2 unaligned write ignored");
    wr('h200, 32'hF);
    rd('h200, 0, "R9 error word unchanged");

    // R6/R7: accepted transfer, then clipped, then R8 zero count
    ask(0, 1'b1, 32'd40); step();
    rd(off(0, 2), m_cnt[0], "R7 count after 40");
    rd(off(0, 1), m_mode[0], "R7 mode TC set");
    ask(0, 1'b1, 32'd100); step();
    rd(off(0, 2), 0, "R6 clipped count zero");
    ask(0, 1'b1, 32'd8); step();
    rd(off(0, 2), 0, "R8 count stays 0");
    rd(off(0, 1), m_mode[0], "R8 mode after zero-length");

    // R4/R5: disabled channel rejected
    ask(1, 1'b1, 32'd4); step();
    rd(off(1, 1), 32'h200, "R5 mode mem-error flag");
    rd('h200, 32'h2, "R5 error bit 1");

    // R4: direction mismatch, then matching request
    wr(off(2, 1), 32'h3);
    wr(off(2, 2), 32'd30);
    wr(off(2, 3), 32'h0000_2000);
    ask(2, 1'b1, 32'd6); step();
    rd(off(2, 1), 32'h203, "R4 mismatch rejected");
    rd('h200, 32'h6, "R5 error bits sticky");
    ask(2, 1'b0, 32'd6); step();
    rd(off(2, 1), 32'h103, "R7 mem-error cleared on accept");

    // R3: simultaneous requests, lowest first, one per cycle
    wr(off(3, 1), 32'h1);
    wr(off(3, 2), 32'd50);
    wr(off(3, 3), 32'h0000_3000);
    wr(off(0, 2), 32'd20);
    ask(0, 1'b1, 32'd5);
    ask(2, 1'b0, 32'd6);
    ask(3, 1'b1, 32'd7);
    step(); step(); step();
    step();

    // R7: address-error flag cleared, other mode bits kept
    wr(off(3, 1), 32'h0001_0401);
    ask(3, 1'b1, 32'd3); step();
    rd(off(3, 1), 32'h0001_0101, "R7 bit10 cleared");

    // final sweep against the model
    for (int c = 0; c < 4; c++) begin
      rd(off(c, 1), m_mode[c], "R2 final mode");
      rd(off(c, 2), m_cnt[c], "R7 final count");
      rd(off(c, 3), m_addr[c], "R2 final addr");
    end
    rd('h200, 32'(m_err), "R5 final error word");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule